// File: doc/BRIEF.md
# Multicast Address Filter Table

This block keeps four 48-bit Ethernet group addresses that a receive path uses to accept multicast frames. Software never touches the table directly. It writes an address into two 32-bit staging words and then issues a command through the upper staging word. A store command copies the staged address into one table entry. A fetch command copies one table entry back into the staging words, where software can read it.

Addresses use wire byte order. The first byte seen on the line sits in bits 7:0, so the address 01-00-5E-00-00-FB is held as 48'hFB00_005E_0001. A lookup port takes a destination address and a strobe, compares the address against every valid entry in parallel, and reports a hit and a per-entry hit mask one clock later. A parameter selects the table contents after reset: all zeros with every entry invalid, or all ones with every entry valid.

Top module: `mcast_filter_table`

## Requirements
- R1: After reset both staging words read as zero, `reg_rdata` is zero, and `mc_hit` and `mc_hit_mask` are low.
- R2: A bus write at offset 0 loads all 32 bits of staging word 0. A read at offset 0 returns that value in `reg_rdata` on the clock after `reg_rd`.
- R3: At offset 4, bits 15:0 hold address bits 47:32 and bits 17:16 hold the entry index. Command bits 23 (go) and 22 (direction) and every other bit, including bit 31 (busy), read as zero.
- R4: A write at offset 4 with bit 23 and bit 22 set stores {wdata[15:0], word 0} into the entry named by wdata[17:16] at that clock edge, and marks the entry valid. Both staging words end up holding the value that was stored.
- R5: A write at offset 4 with bit 23 set and bit 22 clear loads the selected entry into the staging words at that clock edge: bits 31:0 go to word 0 and bits 47:32 go to word 1 bits 15:0. The index field takes wdata[17:16].
- R6: With RESET_ONES = 0, every entry resets to zero and invalid. With RESET_ONES = 1, every entry resets to all ones and valid. A fetch of an untouched entry then returns 32'hFFFF_FFFF and 16'hFFFF.
- R7: If `dst_valid` is high at a clock edge, then on the next cycle `mc_hit_mask[i]` is high exactly when entry i is valid and equal to `dst_addr`, and `mc_hit` is the OR of the mask. Both use the table as it was before that edge.
- R8: A destination address with bit 0 clear (the group bit of the first wire byte) never produces a hit or a mask bit.
- R9: When `dst_valid` is low at a clock edge, `mc_hit` and `mc_hit_mask` are zero on the next cycle.
- R10: Lookup uses the same wire byte order as storage, so a stored 48'hFB00_005E_0001 matches the destination 01-00-5E-00-00-FB presented as 48'hFB00_005E_0001.
- R11: A read at any offset other than 0 or 4 returns zero. A write at any such offset changes nothing.
- R12: `reg_rdata` changes only on the clock after `reg_rd` is high and holds otherwise. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| dst_addr | input | 48 | Destination address to look up, wire byte order |
| dst_valid | input | 1 | Lookup strobe |
| mc_hit | output | 1 | Registered hit on any valid entry |
| mc_hit_mask | output | 4 | Registered per-entry hit mask |

## Verification
Both reset modes run side by side from the same stimulus, because a design that ignored the reset parameter would either match broadcast addresses out of reset or hide stored entries. Store and fetch are checked back to back with a lookup in the same cycle as a store, so a table that updated early, or a fetch that left the index stale, shows up as a wrong hit or a wrong read word. Unicast destinations equal to a stored entry must miss, and a design that skipped the group-bit test would report them. Reads of undecoded offsets and reads issued in the same cycle as a write catch reserved bits that leak through and read data that is not registered.

// File: rtl/mft_pkg.sv
package mft_pkg;

   // register byte offsets
   localparam int OFS_WORD0 = 0;
   localparam int OFS_WORD1 = 4;

   // fields of staging word 1
   localparam int W1_IDX_LSB  = 16;
   localparam int W1_DIR_BIT  = 22;   // 1: store into table, 0: fetch from table
   localparam int W1_GO_BIT   = 23;
   localparam int W1_BUSY_BIT = 31;   // always reads zero: operations finish in one clock

   typedef enum logic [1:0] {
      TBL_IDLE  = 2'd0,
      TBL_STORE = 2'd1,
      TBL_FETCH = 2'd2
   } tbl_op_e;

endpackage

// File: rtl/mft_regbank.sv
module mft_regbank
   import mft_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 48,
   parameter int IDX_W  = 2,
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic              reg_rd,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] fetch_addr,
   output tbl_op_e           op,
   output logic [IDX_W-1:0]  op_idx,
   output logic [ADDR_W-1:0] op_addr,
   output logic [BUS_W-1:0]  stg_w0,
   output logic [ADDR_W-BUS_W-1:0] stg_hi
);

   localparam int HI_W = ADDR_W - BUS_W;
   localparam logic [REG_AW-1:0] A_W0 = REG_AW'(OFS_WORD0);
   localparam logic [REG_AW-1:0] A_W1 = REG_AW'(OFS_WORD1);

   logic             hit_w0;
   logic             hit_w1;
   logic [IDX_W-1:0] stg_idx;
   logic [BUS_W-1:0] w1_image;

   assign hit_w0 = (reg_addr == A_W0);
   assign hit_w1 = (reg_addr == A_W1);

   // command decode from a write to word 1
   always_comb begin
      op = TBL_IDLE;
      if (reg_wr && hit_w1 && reg_wdata[W1_GO_BIT]) begin
         op = reg_wdata[W1_DIR_BIT] ? TBL_STORE : TBL_FETCH;
      end
   end

   assign op_idx  = reg_wdata[W1_IDX_LSB +: IDX_W];
   assign op_addr = {reg_wdata[HI_W-1:0], stg_w0};

   // staging word 0
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_w0 <= '0;
      end else if (op == TBL_FETCH) begin
         stg_w0 <= fetch_addr[BUS_W-1:0];
      end else if (reg_wr && hit_w0) begin
         stg_w0 <= reg_wdata;
      end
   end

   // staging word 1: high address bits and entry index
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_hi  <= '0;
         stg_idx <= '0;
      end else if (reg_wr && hit_w1) begin
         stg_idx <= reg_wdata[W1_IDX_LSB +: IDX_W];
         if (op == TBL_FETCH) begin
            stg_hi <= fetch_addr[ADDR_W-1:BUS_W];
         end else begin
            stg_hi <= reg_wdata[HI_W-1:0];
         end
      end
   end

   always_comb begin
      w1_image = '0;
      w1_image[HI_W-1:0] = stg_hi;
      w1_image[W1_IDX_LSB +: IDX_W] = stg_idx;
   end

   // registered read port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         if (hit_w0) begin
            reg_rdata <= stg_w0;
         end else if (hit_w1) begin
            reg_rdata <= w1_image;
         end else begin
            reg_rdata <= '0;
         end
      end
   end

endmodule

// File: rtl/mft_entry_store.sv
module mft_entry_store #(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 48,
   parameter bit RESET_ONES  = 1'b0,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_stb,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [ADDR_W-1:0]             rd_addr,
   output logic [NUM_ENTRIES*ADDR_W-1:0] entries,
   output logic [NUM_ENTRIES-1:0]        valid
);

   logic [ADDR_W-1:0] fill_val;
   logic              fill_vld;

   // reset contents chosen by parameter
   generate
      if (RESET_ONES) begin : g_fill_ones
         assign fill_val = '1;
         assign fill_vld = 1'b1;
      end else begin : g_fill_zeros
         assign fill_val = '0;
         assign fill_vld = 1'b0;
      end
   endgenerate

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      logic [ADDR_W-1:0] slot_q;
      logic              slot_v;
      logic              take;

      assign take = wr_stb && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= fill_val;
            slot_v <= fill_vld;
         end else if (take) begin
            slot_q <= wr_addr;
            slot_v <= 1'b1;
         end
      end

      assign entries[i*ADDR_W +: ADDR_W] = slot_q;
      assign valid[i] = slot_v;
   end

   always_comb begin
      rd_addr = '0;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
         if (rd_idx == IDX_W'(k)) begin
            rd_addr = entries[k*ADDR_W +: ADDR_W];
         end
      end
   end

endmodule

// File: rtl/mft_lookup.sv
module mft_lookup #(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 48
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             dst_addr,
   input  logic                          dst_valid,
   input  logic [NUM_ENTRIES*ADDR_W-1:0] entries,
   input  logic [NUM_ENTRIES-1:0]        valid,
   output logic                          hit,
   output logic [NUM_ENTRIES-1:0]        hit_mask
);

   logic [NUM_ENTRIES-1:0] eq_vec;
   logic                   group_ok;

   // group bit is bit 0 of the first wire byte
   assign group_ok = dst_valid && dst_addr[0];

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign eq_vec[i] = valid[i] && (entries[i*ADDR_W +: ADDR_W] == dst_addr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit      <= 1'b0;
         hit_mask <= '0;
      end else begin
         hit      <= group_ok && (|eq_vec);
         hit_mask <= group_ok ? eq_vec : '0;
      end
   end

endmodule

// File: rtl/mcast_filter_table.sv
module mcast_filter_table
   import mft_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 48,
   parameter int BUS_W       = 32,
   parameter int REG_AW      = 3,
   parameter bit RESET_ONES  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic              reg_rd,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              dst_valid,
   output logic              mc_hit,
   output logic [NUM_ENTRIES-1:0] mc_hit_mask
);

   localparam int IDX_W = $clog2(NUM_ENTRIES);
   localparam int HI_W  = ADDR_W - BUS_W;

   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2 || NUM_ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two of at least 2");
   end
   if (HI_W < 1 || HI_W > W1_IDX_LSB) begin : g_bad_split
      $error("ADDR_W - BUS_W must fit below the index field");
   end
   if (W1_IDX_LSB + IDX_W > W1_DIR_BIT) begin : g_bad_idx
      $error("index field overlaps command bits");
   end
   if (REG_AW < 3) begin : g_bad_aw
      $error("REG_AW must reach offset 4");
   end

   tbl_op_e           op;
   logic [IDX_W-1:0]  op_idx;
   logic [ADDR_W-1:0] op_addr;
   logic [ADDR_W-1:0] fetch_addr;
   logic [BUS_W-1:0]  stg_w0;
   logic [HI_W-1:0]   stg_hi;
   logic [NUM_ENTRIES*ADDR_W-1:0] tbl_flat;
   logic [NUM_ENTRIES-1:0]        tbl_valid;

   mft_regbank #(
      .BUS_W (BUS_W),
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W),
      .REG_AW(REG_AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .fetch_addr(fetch_addr),
      .op        (op),
      .op_idx    (op_idx),
      .op_addr   (op_addr),
      .stg_w0    (stg_w0),
      .stg_hi    (stg_hi)
   );

   mft_entry_store #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .ADDR_W     (ADDR_W),
      .RESET_ONES (RESET_ONES)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (op == TBL_STORE),
      .wr_idx (op_idx),
      .wr_addr(op_addr),
      .rd_idx (op_idx),
      .rd_addr(fetch_addr),
      .entries(tbl_flat),
      .valid  (tbl_valid)
   );

   mft_lookup #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .ADDR_W     (ADDR_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .dst_addr (dst_addr),
      .dst_valid(dst_valid),
      .entries  (tbl_flat),
      .valid    (tbl_valid),
      .hit      (mc_hit),
      .hit_mask (mc_hit_mask)
   );

endmodule

// File: rtl/mft_checker.sv
module mft_checker
   import mft_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 48,
   parameter int BUS_W       = 32,
   parameter int REG_AW      = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [REG_AW-1:0]             reg_addr,
   input logic                          reg_wr,
   input logic [BUS_W-1:0]              reg_wdata,
   input logic                          reg_rd,
   input logic [BUS_W-1:0]              reg_rdata,
   input logic [ADDR_W-1:0]             dst_addr,
   input logic                          dst_valid,
   input logic                          mc_hit,
   input logic [NUM_ENTRIES-1:0]        mc_hit_mask,
   input logic [NUM_ENTRIES*ADDR_W-1:0] entries,
   input logic [BUS_W-1:0]              stg_w0,
   input logic [ADDR_W-BUS_W-1:0]       stg_hi
);

   localparam int IDX_W = $clog2(NUM_ENTRIES);
   localparam int HI_W  = ADDR_W - BUS_W;

   logic              was_store;
   logic              was_fetch;
   logic              was_rd;
   logic              was_rd_w1;
   logic              was_rd_other;
   logic [IDX_W-1:0]  last_idx;
   logic [ADDR_W-1:0] last_val;
   logic [ADDR_W-1:0] sel_entry;
   logic              w1_go;

   assign w1_go = reg_wr && (reg_addr == REG_AW'(OFS_WORD1)) && reg_wdata[W1_GO_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         was_store    <= 1'b0;
         was_fetch    <= 1'b0;
         was_rd       <= 1'b0;
         was_rd_w1    <= 1'b0;
         was_rd_other <= 1'b0;
         last_idx     <= '0;
         last_val     <= '0;
      end else begin
         was_store    <= w1_go && reg_wdata[W1_DIR_BIT];
         was_fetch    <= w1_go && !reg_wdata[W1_DIR_BIT];
         was_rd       <= reg_rd;
         was_rd_w1    <= reg_rd && (reg_addr == REG_AW'(OFS_WORD1));
         was_rd_other <= reg_rd && (reg_addr != REG_AW'(OFS_WORD0))
                                && (reg_addr != REG_AW'(OFS_WORD1));
         last_idx     <= reg_wdata[W1_IDX_LSB +: IDX_W];
         last_val     <= {reg_wdata[HI_W-1:0], stg_w0};
      end
   end

   always_comb begin
      sel_entry = '0;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
         if (last_idx == IDX_W'(k)) sel_entry = entries[k*ADDR_W +: ADDR_W];
      end
   end

   assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      was_store |-> (sel_entry == last_val));

   assert_fetch_fills_staging_R5: assert property (@(posedge clk) disable iff (!rst_n)
      was_fetch |-> ({stg_hi, stg_w0} == sel_entry));

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      was_rd_w1 |-> (reg_rdata[BUS_W-1:W1_IDX_LSB+IDX_W] == '0));

   assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      was_rd_other |-> (reg_rdata == '0));

   assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd && was_rd == 1'b0) |=> $stable(reg_rdata));

   assert_unicast_misses_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_addr[0]) |=> (!mc_hit && mc_hit_mask == '0));

   assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_valid |=> (!mc_hit && mc_hit_mask == '0));

   assert_hit_has_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mc_hit |-> ($countones(mc_hit_mask) > 0));

endmodule

bind mcast_filter_table mft_checker #(
   .NUM_ENTRIES(NUM_ENTRIES),
   .ADDR_W     (ADDR_W),
   .BUS_W      (BUS_W),
   .REG_AW     (REG_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rd     (reg_rd),
   .reg_rdata  (reg_rdata),
   .dst_addr   (dst_addr),
   .dst_valid  (dst_valid),
   .mc_hit     (mc_hit),
   .mc_hit_mask(mc_hit_mask),
   .entries    (tbl_flat),
   .stg_w0     (stg_w0),
   .stg_hi     (stg_hi)
);

// File: tb/mcast_filter_table_test.sv
`timescale 1ns/1ps
module mcast_filter_table_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [47:0] dst_addr = '0;
   logic        dst_valid = 1'b0;

   logic [31:0] rd_o [2];
   logic        hit_o [2];
   logic [3:0]  mask_o [2];

   always #2 clk = ~clk;   // 250 MHz

   mcast_filter_table #(.RESET_ONES(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rd_o[0]),
      .dst_addr(dst_addr), .dst_valid(dst_valid),
      .mc_hit(hit_o[0]), .mc_hit_mask(mask_o[0]));

   mcast_filter_table #(.RESET_ONES(1'b1)) uut_ones (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rd_o[1]),
      .dst_addr(dst_addr), .dst_valid(dst_valid),
      .mc_hit(hit_o[1]), .mc_hit_mask(mask_o[1]));

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference model, one per reset mode
   logic [47:0] m_ent [2][4];
   bit          m_vld [2][4];
   logic [31:0] m_w0 [2];
   logic [15:0] m_hi [2];
   logic [1:0]  m_sel [2];
   logic [31:0] e_rd [2];
   bit          e_hit [2];
   logic [3:0]  e_mask [2];

   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (!rst_n) begin
            m_w0[m] = '0; m_hi[m] = '0; m_sel[m] = '0;
            e_rd[m] = '0; e_hit[m] = 0; e_mask[m] = '0;
            for (int e = 0; e < 4; e++) begin
               m_ent[m][e] = (m == 1) ? 48'hFFFF_FFFF_FFFF : 48'h0;
               m_vld[m][e] = (m == 1);
            end
         end else begin
            logic [3:0] mk;
            mk = '0;
            for (int e = 0; e < 4; e++)
               if (dst_valid && dst_addr[0] && m_vld[m][e] && m_ent[m][e] == dst_addr) mk[e] = 1'b1;
            e_mask[m] = mk;
            e_hit[m] = (mk != 0);
            if (reg_rd) begin
               if (reg_addr == 3'd0) e_rd[m] = m_w0[m];
               else if (reg_addr == 3'd4) e_rd[m] = {14'd0, m_sel[m], m_hi[m]};
               else e_rd[m] = '0;
            end
            if (reg_wr && reg_addr == 3'd0) m_w0[m] = reg_wdata;
            if (reg_wr && reg_addr == 3'd4) begin
               m_hi[m] = reg_wdata[15:0];
               m_sel[m] = reg_wdata[17:16];
               if (reg_wdata[23]) begin
                  if (reg_wdata[22]) begin
                     m_ent[m][m_sel[m]] = {m_hi[m], m_w0[m]};
                     m_vld[m][m_sel[m]] = 1;
                  end else begin
                     {m_hi[m], m_w0[m]} = m_ent[m][m_sel[m]];
                  end
               end
            end
         end
      end
   end

   task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int m = 0; m < 2; m++) begin
            check(cur_req, (m == 0) ? "rdata zero-mode" : "rdata ones-mode", 48'(rd_o[m]), 48'(e_rd[m]));
            check(cur_req, (m == 0) ? "hit zero-mode" : "hit ones-mode", 48'(hit_o[m]), 48'(e_hit[m]));
            check(cur_req, (m == 0) ? "mask zero-mode" : "mask ones-mode", 48'(mask_o[m]), 48'(e_mask[m]));
         end
      end
   end

   task automatic idle();
      reg_wr = 0; reg_rd = 0; dst_valid = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a);
      reg_addr = a; reg_rd = 1; reg_wr = 0;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic look(input logic [47:0] a, input bit v);
      dst_addr = a; dst_valid = v;
      @(negedge clk);
      dst_valid = 0;
   endtask

   task automatic store(input logic [1:0] idx, input logic [47:0] a);
      wr(3'd0, a[31:0]);
      wr(3'd4, {8'h00, 2'b11, 4'h0, idx, a[47:32]});
   endtask

   task automatic fetch(input logic [1:0] idx);
      wr(3'd4, {8'h00, 2'b10, 4'h0, idx, 16'h0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R1";
      check("R1", "rdata after reset", 48'(rd_o[0]), 48'h0);
      check("R1", "hit after reset", 48'(hit_o[0]), 48'h0);
      rd(3'd0); rd(3'd4); idle();
      check("R1", "word1 after reset", 48'(rd_o[0]), 48'h0);

      cur_req = "R6";
      look(48'hFFFF_FFFF_FFFF, 1); idle();
      fetch(2'd3); rd(3'd0); rd(3'd4); idle();
      check("R6", "ones-mode fetched hi", 48'(rd_o[1]), 48'h3_FFFF);
      check("R6", "zero-mode fetched hi", 48'(rd_o[0]), 48'h3_0000);

      cur_req = "R2";
      wr(3'd0, 32'hA5A5_5A5A); rd(3'd0); idle();
      check("R2", "word0 readback", 48'(rd_o[0]), 48'hA5A5_5A5A);
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0); wr(3'd0, 32'h0); rd(3'd0); idle();

      cur_req = "R3";
      wr(3'd4, 32'hFF3F_FFFF); rd(3'd4); idle();
      check("R3", "word1 reserved bits", 48'(rd_o[0]), 48'h3_FFFF);

      cur_req = "R10";
      store(2'd2, 48'hFB00_005E_0001); idle();
      look(48'hFB00_005E_0001, 1); idle();
      check("R10", "wire-order mask", 48'(mask_o[0]), 48'h0);
      look(48'hFB00_005E_0001, 1);
      check("R10", "wire-order hit mask", 48'(mask_o[0]), 48'h4);

      cur_req = "R4";
      store(2'd0, 48'h3333_4444_5555); store(2'd1, 48'h1111_2222_3333);
      store(2'd3, 48'hFB00_005E_0001); look(48'hFB00_005E_0001, 1); idle();
      // lookup in the same cycle as a store sees the old table
      wr(3'd0, 32'h2222_0001);
      reg_addr = 3'd4; reg_wdata = 32'h00C0_1111; reg_wr = 1;
      dst_addr = 48'h1111_2222_0001; dst_valid = 1;
      @(negedge clk);
      reg_wr = 0; dst_valid = 0;
      look(48'h1111_2222_0001, 1); idle();

      cur_req = "R5";
      for (int i = 0; i < 4; i++) begin
         fetch(2'(i)); rd(3'd0); rd(3'd4);
      end
      idle();

      cur_req = "R8";
      store(2'd1, 48'h0123_4567_89AA); look(48'h0123_4567_89AA, 1); idle();
      check("R8", "unicast never hits", 48'(hit_o[0]), 48'h0);

      cur_req = "R9";
      look(48'h1111_2222_0001, 0); idle();
      check("R9", "no strobe no hit", 48'(hit_o[0]), 48'h0);

      cur_req = "R11";
      wr(3'd2, 32'hDEAD_BEEF); wr(3'd6, 32'hFFFF_FFFF); rd(3'd2); idle();
      check("R11", "unmapped read", 48'(rd_o[0]), 48'h0);
      rd(3'd6); rd(3'd0); rd(3'd4); idle();

      cur_req = "R12";
      reg_addr = 3'd0; reg_wdata = 32'h7777_8888; reg_wr = 1; reg_rd = 1;
      @(negedge clk);
      reg_wr = 0; reg_rd = 0;
      repeat (3) idle();
      rd(3'd0); idle();

      cur_req = "R7";
      for (int n = 0; n < 600; n++) begin
         int op;
         logic [47:0] pool [4];
         pool[0] = 48'hFB00_005E_0001; pool[1] = 48'h1111_2222_0001;
         pool[2] = 48'h0123_4567_89AA; pool[3] = 48'hFFFF_FFFF_FFFF;
         op = $urandom_range(0, 5);
         reg_addr = 3'($urandom_range(0, 7));
         if (op == 0) reg_addr = 3'd0;
         if (op == 1) reg_addr = 3'd4;
         reg_wdata = (op == 0) ? pool[$urandom_range(0, 3)][31:0] : $urandom;
         if (op == 1) reg_wdata[15:0] = pool[$urandom_range(0, 3)][47:32];
         reg_wr = (op <= 2);
         reg_rd = $urandom_range(0, 1);
         dst_addr = pool[$urandom_range(0, 3)];
         dst_valid = $urandom_range(0, 1);
         @(negedge clk);
      end
      idle(); idle();

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule